// File: doc/BRIEF.md
# Dual-Output Saw-Wave PWM Timer

This block is one timer channel that produces two pulse-width-modulated outputs from a single up-counter. A power-of-four prescaler gates the counter, so each counter step takes 1, 4, 16, 64, 256 or 1024 clocks. The counter climbs to a shared period value and then restarts from zero, which gives a saw-wave timebase. Each output has its own compare value. When the counter matches that value the output toggles. At each wrap the output is forced to a fixed level. A small pin-function code sets the level an output starts from and the level it takes at the wrap.

A host sets the channel up through a plain register bus. The bus has a write strobe, a read strobe, a 3-bit word address and 32-bit data. Read data appears one cycle after the read strobe. The register layout is: control at 0, pin setup at 1, counter at 2, period at 3, compare A at 4 and compare B at 5. While the run bit is clear the counter holds its value and both outputs stay low. A one-clock wrap pulse marks every return of the counter to zero. There is no streaming data path, so every pin is a plain control or status signal and none uses a valid/ready handshake.

Top module: `pwm_saw_timer`

## Requirements
- R1: After reset all six registers read back as 0, and `pwm_a`, `pwm_b` and `wrap_pulse` are low.
- R2: Control bits 10:8 hold the divide select n. The counter steps once every 4^n clocks. Codes 6 and 7 behave as code 5, which is divide-by-1024.
- R3: Control bit 0 is the run bit. The counter and the prescaler advance only while this bit is 1. After the bit is cleared, the counter holds its value.
- R4: The counter goes from the period value P to 0 on its next step. The distance between consecutive `wrap_pulse` assertions is (P+1)·4^n clocks. Each assertion lasts one clock and comes in the cycle in which the counter reads 0.
- R5: The mode field (control bits 6:4) and the divide select can be written only while the run bit is 0. A control write made while the counter runs updates only the run bit.
- R6: Pin code 0x1B starts the output high, forces it high at each wrap and toggles it on a compare match. With compare value C < P the output is high for (C+1)·4^n clocks of each period.
- R7: Pin code 0x07 starts the output low, forces it low at each wrap and toggles it on a compare match. With C < P the output is high for (P−C)·4^n clocks of each period.
- R8: When C equals P, the forced wrap level wins over the toggle. When C is greater than P there is never a match. In both cases the output stays at its wrap level for the whole period.
- R9: The pin-setup register holds the A code in bits 4:0, the A enable in bit 8, the B code in bits 20:16 and the B enable in bit 24. An output whose enable bit is 0, or whose code is neither 0x1B nor 0x07, stays low.
- R10: While the run bit is 0, both outputs are low.
- R11: Writes to the counter, period and compare registers take effect on the next clock, with no buffering. Every register reads back the value last written to it, and the counter reads back its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| wrap_pulse | output | 1 | One-clock pulse at each counter wrap |

## Verification
The single-clock wrap-pulse property assumes that the period is at least 1 whenever the divide select is 0. With period 0 and no division the counter would wrap on every clock. The counter-hold and wrap properties also assume that the counter is never preset above the period while it runs. The stimulus keeps within these limits: random periods start at 1, and the counter is written to 0 while stopped before every start. Compare values range up to two above the period, so the equal and beyond-period cases of R8 are covered.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 3;
  localparam int PIN_CODE_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_PIN    = 3'd1,
    REG_COUNT  = 3'd2,
    REG_PERIOD = 3'd3,
    REG_CMPA   = 3'd4,
    REG_CMPB   = 3'd5
  } reg_addr_e;

  localparam logic [PIN_CODE_W-1:0] PIN_HI_TOGGLE = 5'h1B;
  localparam logic [PIN_CODE_W-1:0] PIN_LO_TOGGLE = 5'h07;

  typedef struct packed {
    logic known;
    logic start_lvl;
    logic end_lvl;
  } pin_plan_t;

  function automatic pin_plan_t decode_pin(input logic [PIN_CODE_W-1:0] code);
    pin_plan_t p;
    p = '0;
    if (code == PIN_HI_TOGGLE) begin
      p.known = 1'b1; p.start_lvl = 1'b1; p.end_lvl = 1'b1;
    end else if (code == PIN_LO_TOGGLE) begin
      p.known = 1'b1;
    end
    return p;
  endfunction
endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = 2 * MAX_SEL;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  int               eff;

  always_comb begin
    eff = (int'(sel) > MAX_SEL) ? MAX_SEL : int'(sel);
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < 2 * eff);
  end

  assign tick = run && (div_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (!run || tick)  div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> !tick);
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_en)  cnt <= wr_val;
    else if (wrap)   cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !wr_en) |=> cnt == '0);
endmodule

// File: rtl/pwmt_pin.sv
module pwmt_pin
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  tick,
  input  logic                  wrap,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [CNT_W-1:0]      cmp,
  input  logic [PIN_CODE_W-1:0] code,
  input  logic                  en,
  output logic                  pin
);
  pin_plan_t plan;
  logic      lvl_q;
  logic      hit;

  assign plan = decode_pin(code);
  assign hit  = tick && (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lvl_q <= 1'b0;
    else if (!run || !plan.known)    lvl_q <= plan.start_lvl;
    else if (wrap)                   lvl_q <= plan.end_lvl;
    else if (hit)                    lvl_q <= !lvl_q;
  end

  assign pin = en && run && plan.known && lvl_q;

  // R8
  end_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && plan.known) |=> lvl_q == $past(plan.end_lvl));
endmodule

// File: rtl/pwm_saw_timer.sv
module pwm_saw_timer
  import pwmt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 5,
  parameter int MODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              wrap_pulse
);
  localparam int NUM_OUT  = 2;
  localparam int MODE_LSB = 4;
  localparam int SEL_LSB  = 8;
  localparam int HALF     = 16;
  localparam int EN_BIT   = 8;

  logic                  run_q;
  logic [MODE_W-1:0]     mode_q;
  logic [SEL_W-1:0]      sel_q;
  logic [CNT_W-1:0]      period_q;
  logic [CNT_W-1:0]      cmp_q  [NUM_OUT];
  logic [PIN_CODE_W-1:0] code_q [NUM_OUT];
  logic                  en_q   [NUM_OUT];
  logic [NUM_OUT-1:0]    pins;
  logic                  tick, wrap, cnt_we;
  logic [CNT_W-1:0]      cnt;
  logic [DATA_W-1:0]     ctrl_word, pin_word, rd_mux;

  assign cnt_we = bus_wr && (bus_addr == REG_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; mode_q <= '0; sel_q <= '0; period_q <= '0;
      for (int i = 0; i < NUM_OUT; i++) begin
        cmp_q[i] <= '0; code_q[i] <= '0; en_q[i] <= 1'b0;
      end
    end else if (bus_wr) begin
      case (bus_addr)
        REG_CTRL: begin
          run_q <= bus_wdata[0];
          if (!run_q) begin
            mode_q <= bus_wdata[MODE_LSB +: MODE_W];
            sel_q  <= bus_wdata[SEL_LSB +: SEL_W];
          end
        end
        REG_PIN: begin
          for (int i = 0; i < NUM_OUT; i++) begin
            code_q[i] <= bus_wdata[i*HALF +: PIN_CODE_W];
            en_q[i]   <= bus_wdata[i*HALF + EN_BIT];
          end
        end
        REG_PERIOD: period_q <= bus_wdata[CNT_W-1:0];
        REG_CMPA:   cmp_q[0] <= bus_wdata[CNT_W-1:0];
        REG_CMPB:   cmp_q[1] <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  pwmt_prescale #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_prescale (
    .clk(clk), .rst_n(rst_n), .run(run_q), .sel(sel_q), .tick(tick));

  pwmt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period_q),
    .wr_en(cnt_we), .wr_val(bus_wdata[CNT_W-1:0]), .cnt(cnt), .wrap(wrap));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    pwmt_pin #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .wrap(wrap),
      .cnt(cnt), .cmp(cmp_q[g]), .code(code_q[g]), .en(en_q[g]),
      .pin(pins[g]));
  end

  assign pwm_a = pins[0];
  assign pwm_b = pins[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrap_pulse <= 1'b0;
    else        wrap_pulse <= wrap;
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[0] = run_q;
    ctrl_word[MODE_LSB +: MODE_W] = mode_q;
    ctrl_word[SEL_LSB +: SEL_W]   = sel_q;
    pin_word = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      pin_word[i*HALF +: PIN_CODE_W] = code_q[i];
      pin_word[i*HALF + EN_BIT]      = en_q[i];
    end
    case (bus_addr)
      REG_CTRL:   rd_mux = ctrl_word;
      REG_PIN:    rd_mux = pin_word;
      REG_COUNT:  rd_mux = DATA_W'(cnt);
      REG_PERIOD: rd_mux = DATA_W'(period_q);
      REG_CMPA:   rd_mux = DATA_W'(cmp_q[0]);
      REG_CMPB:   rd_mux = DATA_W'(cmp_q[1]);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R5
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(sel_q) && $stable(mode_q));
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_we) |=> $stable(cnt));
  // R4
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_pulse && !(sel_q == '0 && period_q == '0)) |=> !wrap_pulse);
  // R4
  wrap_zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_pulse && !$past(cnt_we)) |-> cnt == '0);
endmodule

// File: tb/pwm_saw_timer_bench.sv
module pwm_saw_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_a, pwm_b, wrap_pulse;

  int checks = 0, errors = 0, cycles = 0;

  pwm_saw_timer u_pwm_saw_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .wrap_pulse(wrap_pulse));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog expired: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic int div_of(input int sel);
    return 1 << (2 * ((sel > 5) ? 5 : sel));
  endfunction

  function automatic int exp_period(input int p, input int sel);
    return (p + 1) * div_of(sel);
  endfunction

  function automatic int exp_high(input int code, input bit en, input int p, input int c, input int sel);
    if (!en) return 0;
    if (code == 'h1B) return ((c >= p) ? p + 1 : c + 1) * div_of(sel);
    if (code == 'h07) return ((c >= p) ? 0 : p - c) * div_of(sel);
    return 0;
  endfunction

  // Waits for a wrap pulse, then counts clocks and high clocks until the next one.
  task automatic measure(output int per, output int hia, output int hib);
    int guard;
    per = 0; hia = 0; hib = 0; guard = 0;
    while (!wrap_pulse && guard < 5000) begin @(negedge clk); guard++; end
    do begin
      per++; hia += int'(pwm_a); hib += int'(pwm_b);
      @(negedge clk);
    end while (!wrap_pulse && per < 5000);
  endtask

  task automatic run_case(input int p, input int ca, input int cb, input int coda,
                          input int codb, input bit ena, input bit enb, input int sel,
                          input string tag);
    int per, hia, hib;
    wr(3'd0, 32'd0);
    wr(3'd3, p);
    wr(3'd4, ca);
    wr(3'd5, cb);
    wr(3'd1, (32'(enb) << 24) | (32'(codb) << 16) | (32'(ena) << 8) | 32'(coda));
    wr(3'd0, 32'(sel) << 8);
    wr(3'd2, 32'd0);
    wr(3'd0, (32'(sel) << 8) | 32'd1);
    measure(per, hia, hib);
    check(per == exp_period(p, sel), {tag, " period R4"}, per, exp_period(p, sel));
    check(hia == exp_high(coda, ena, p, ca, sel), {tag, " output A"}, hia, exp_high(coda, ena, p, ca, sel));
    check(hib == exp_high(codb, enb, p, cb, sel), {tag, " output B"}, hib, exp_high(codb, enb, p, cb, sel));
  endtask

  initial begin
    logic [31:0] d, d2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pwm_a == 0 && pwm_b == 0 && wrap_pulse == 0, "R1 outputs low", pwm_a | pwm_b | wrap_pulse, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check(d == 0, "R1 register reset", d, 0);
    end

    // R6 R7 R9 basic pair, divide-by-1
    run_case(9, 3, 6, 'h1B, 'h07, 1, 1, 0, "R6 R7 basic");
    // R5 divide select and mode frozen while running
    wr(3'd0, (32'd2 << 8) | (32'd3 << 4) | 32'd1);
    rd(3'd0, d);
    check(d == 1, "R5 ctrl write while running", d, 1);
    // R10 stop forces outputs low, R3 counter holds
    wr(3'd0, 32'd0);
    repeat (3) @(negedge clk);
    check(pwm_a == 0 && pwm_b == 0, "R10 outputs low when stopped", pwm_a | pwm_b, 0);
    rd(3'd2, d);
    repeat (7) @(negedge clk);
    rd(3'd2, d2);
    check(d == d2, "R3 counter holds when stopped", d2, d);
    // R11 direct register writes and readback
    wr(3'd2, 32'd5);
    rd(3'd2, d);
    check(d == 5, "R11 counter preset", d, 5);
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd3, d);
    check(d == 32'hDEAD_BEEF, "R11 period readback", d, 32'hDEAD_BEEF);
    wr(3'd1, 32'h011B_0107);
    rd(3'd1, d);
    check(d == 32'h011B_0107, "R9 pin setup field layout", d, 32'h011B_0107);
    wr(3'd0, 32'h0000_0530);
    rd(3'd0, d);
    check(d == 32'h0000_0530, "R5 fields writable while stopped", d, 32'h0000_0530);

    // R2 largest divide and clamped codes
    run_case(1, 0, 0, 'h1B, 'h07, 1, 1, 5, "R2 divide 1024");
    run_case(1, 0, 1, 'h1B, 'h07, 1, 1, 7, "R2 code 7 clamps");
    run_case(3, 1, 2, 'h07, 'h1B, 1, 1, 2, "R2 divide 16");
    // R8 compare at and beyond the period
    run_case(6, 6, 6, 'h1B, 'h07, 1, 1, 0, "R8 compare equals period");
    run_case(6, 8, 8, 'h1B, 'h07, 1, 1, 1, "R8 compare beyond period");
    // R9 disabled output and unknown code
    run_case(5, 2, 2, 'h1B, 'h05, 0, 1, 0, "R9 disabled and unknown code");

    // Random sweep for R4 R6 R7
    for (int k = 0; k < 25; k++) begin
      int p, ca, cb, sel, coda, codb;
      p    = 1 + int'($urandom_range(29));
      ca   = int'($urandom_range(p + 2));
      cb   = int'($urandom_range(p + 2));
      sel  = int'($urandom_range(2));
      coda = ($urandom_range(1) == 1) ? 'h1B : 'h07;
      codb = ($urandom_range(1) == 1) ? 'h1B : 'h07;
      run_case(p, ca, cb, coda, codb, 1, 1, sel, "random R6 R7");
    end

    wr(3'd0, 32'd0);
    @(negedge clk);
    check(pwm_a == 0 && pwm_b == 0, "R10 final stop", pwm_a | pwm_b, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule